// File: doc/BRIEF.md
# Tournament Two-Minimum Finder

This block takes a set of N = 2^L unsigned values and returns the smallest and the second smallest of them. A single `start_i` pulse loads the whole set from one wide input vector. The block then runs a knockout tournament, one tree level per clock. At every pairing the two competing values swap into each other's small per-item record, so each item ends up holding the list of values it has met.

The overall winner is the smallest value. Its record holds exactly one opponent per level, and the true runner-up must be among those opponents, because it loses only to the minimum. One extra cycle scans the winner's L recorded opponents with L-1 comparators and yields the second minimum. A one-cycle `done_o` pulse then presents both results. The results stay on the outputs until the next pulse.

Top module: `tmin2_top`

## Requirements
- R1: While `rst_ni` is low and after it is released, with no start, `done_o` is 0 and `min1_o` and `min2_o` are 0.
- R2: A start accepted at a clock edge raises `done_o` for exactly one cycle, in the cycle that follows the (L+1)-th edge after the accepting edge: L tournament levels plus one reduction. No other cycle has `done_o` high.
- R3: Item k of the set occupies `data_i[k*DATA_W +: DATA_W]`, unsigned. When `done_o` is high, `min1_o` equals the smallest item of the set.
- R4: When `done_o` is high, `min2_o` equals the second entry of the set sorted ascending (duplicates kept), so `min1_o <= min2_o`.
- R5: Equal values resolve deterministically, with the higher-indexed item of a pair losing. A set whose minimum occurs twice returns that value on both outputs, and a set of all-equal items returns that value on both outputs.
- R6: Between `done_o` pulses, `min1_o` and `min2_o` hold their values. Changes on `data_i` with `start_i` low have no effect on them.
- R7: A `start_i` that arrives while a set is in progress is ignored. The running set's result and its `done_o` timing are unchanged.
- R8: A `start_i` in the same cycle as `done_o` is accepted, and its set completes with normal timing.
- R9: For the eight items 10, 1, 5, 8, 7, 9, 12, 11 (item 0 first), the winner's record holds 10, 5 and 7, so the outputs are 1 and 5.
- R10: The extreme values 0 and 2^DATA_W-1 are handled, including a minimum and runner-up that meet in the very first pairing at the top index pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load the set and begin (ignored while busy) |
| data_i | input | 2^LOG_N*DATA_W | Packed input set, item k at bits k*DATA_W upward |
| done_o | output | 1 | One-cycle result strobe |
| min1_o | output | DATA_W | Smallest item of the last completed set |
| min2_o | output | DATA_W | Second smallest item of the last completed set |

## Verification
A new `start_i` can coincide with the `done_o` pulse of the previous set, so result delivery and the next load fall in the same cycle. The bench drives the next set's start in exactly the cycle where `done_o` is observed high. It checks that the previous results are intact in that cycle and that the new set completes L+1 edges later with its own correct minima. A behavioural reference model, built on sorted queues and a countdown, is compared against `done_o`, `min1_o` and `min2_o` on every clock. This comparison also judges starts that land mid-run, which must leave the running set's result and timing untouched.

// File: rtl/tmin2_pkg.sv
package tmin2_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FINISH
  } tmin2_state_e;
endpackage

// File: rtl/tmin2_cell.sv
// One pairing: lower/upper swap by value, each side logs the other at slot lvl_i.
module tmin2_cell #(
  parameter int DATA_W = 8,
  parameter int LOG_N  = 3,
  localparam int LVL_W = (LOG_N > 1) ? $clog2(LOG_N) : 1
) (
  input  logic [LVL_W-1:0]              lvl_i,
  input  logic [DATA_W-1:0]             lo_val_i,
  input  logic [LOG_N-1:0][DATA_W-1:0]  lo_mem_i,
  input  logic [DATA_W-1:0]             hi_val_i,
  input  logic [LOG_N-1:0][DATA_W-1:0]  hi_mem_i,
  output logic [DATA_W-1:0]             win_val_o,
  output logic [LOG_N-1:0][DATA_W-1:0]  win_mem_o,
  output logic [DATA_W-1:0]             lose_val_o,
  output logic [LOG_N-1:0][DATA_W-1:0]  lose_mem_o
);
  logic hi_wins;

  // strict compare: on a tie the upper item loses
  assign hi_wins = hi_val_i < lo_val_i;

  always_comb begin
    win_val_o  = hi_wins ? hi_val_i : lo_val_i;
    lose_val_o = hi_wins ? lo_val_i : hi_val_i;
    win_mem_o  = hi_wins ? hi_mem_i : lo_mem_i;
    lose_mem_o = hi_wins ? lo_mem_i : hi_mem_i;
    win_mem_o[lvl_i]  = lose_val_o;
    lose_mem_o[lvl_i] = win_val_o;
  end
endmodule

// File: rtl/tmin2_reduce.sv
// Minimum over the winner's L logged opponents, L-1 comparators.
module tmin2_reduce #(
  parameter int DATA_W = 8,
  parameter int LOG_N  = 3
) (
  input  logic [LOG_N-1:0][DATA_W-1:0] ent_i,
  output logic [DATA_W-1:0]            min_o
);
  logic [DATA_W-1:0] run [LOG_N];

  assign run[0] = ent_i[0];

  for (genvar k = 1; k < LOG_N; k++) begin : g_cmp
    assign run[k] = (ent_i[k] < run[k-1]) ? ent_i[k] : run[k-1];
  end

  assign min_o = run[LOG_N-1];
endmodule

// File: rtl/tmin2_top.sv
module tmin2_top
  import tmin2_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LOG_N  = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              start_i,
  input  logic [(1<<LOG_N)*DATA_W-1:0]      data_i,
  output logic                              done_o,
  output logic [DATA_W-1:0]                 min1_o,
  output logic [DATA_W-1:0]                 min2_o
);
  localparam int NUM   = 1 << LOG_N;
  localparam int HALF  = NUM / 2;
  localparam int LVL_W = (LOG_N > 1) ? $clog2(LOG_N) : 1;
  localparam int IDX_W = LOG_N;
  localparam int SH_W  = 2 * LOG_N + 1;

  typedef logic [LOG_N-1:0][DATA_W-1:0] mem_t;

  tmin2_state_e      state_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [DATA_W-1:0] val_q [NUM];
  logic [DATA_W-1:0] val_d [NUM];
  mem_t              mem_q [NUM];
  mem_t              mem_d [NUM];
  logic              done_q;
  logic [DATA_W-1:0] min1_q, min2_q, min2_d;

  logic              c_act    [HALF];
  logic [IDX_W-1:0]  c_lo     [HALF];
  logic [IDX_W-1:0]  c_hi     [HALF];
  logic [DATA_W-1:0] c_win_v  [HALF];
  logic [DATA_W-1:0] c_lose_v [HALF];
  mem_t              c_win_m  [HALF];
  mem_t              c_lose_m [HALF];

  // Cell g pairs slots g*2^(lvl+1) and that + 2^lvl; winner stays in the lower slot.
  for (genvar g = 0; g < HALF; g++) begin : g_cell
    logic [SH_W-1:0] lo_full;

    assign lo_full  = SH_W'(g) << ({1'b0, lvl_q} + (LVL_W+1)'(1));
    assign c_act[g] = (lo_full[SH_W-1:IDX_W] == '0);
    assign c_lo[g]  = lo_full[IDX_W-1:0];
    assign c_hi[g]  = lo_full[IDX_W-1:0] + (IDX_W'(1) << lvl_q);

    tmin2_cell #(
      .DATA_W (DATA_W),
      .LOG_N  (LOG_N)
    ) u_cell (
      .lvl_i      (lvl_q),
      .lo_val_i   (val_q[c_lo[g]]),
      .lo_mem_i   (mem_q[c_lo[g]]),
      .hi_val_i   (val_q[c_hi[g]]),
      .hi_mem_i   (mem_q[c_hi[g]]),
      .win_val_o  (c_win_v[g]),
      .win_mem_o  (c_win_m[g]),
      .lose_val_o (c_lose_v[g]),
      .lose_mem_o (c_lose_m[g])
    );
  end

  always_comb begin
    val_d = val_q;
    mem_d = mem_q;
    for (int c = 0; c < HALF; c++) begin
      if (c_act[c]) begin
        val_d[c_lo[c]] = c_win_v[c];
        mem_d[c_lo[c]] = c_win_m[c];
        val_d[c_hi[c]] = c_lose_v[c];
        mem_d[c_hi[c]] = c_lose_m[c];
      end
    end
  end

  tmin2_reduce #(
    .DATA_W (DATA_W),
    .LOG_N  (LOG_N)
  ) u_reduce (
    .ent_i (mem_q[0]),
    .min_o (min2_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      done_q  <= 1'b0;
      min1_q  <= '0;
      min2_q  <= '0;
      for (int i = 0; i < NUM; i++) begin
        val_q[i] <= '0;
        mem_q[i] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            for (int i = 0; i < NUM; i++) begin
              val_q[i] <= data_i[i*DATA_W +: DATA_W];
              mem_q[i] <= '0;
            end
            lvl_q   <= '0;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          val_q <= val_d;
          mem_q <= mem_d;
          if (lvl_q == LVL_W'(LOG_N - 1)) state_q <= ST_FINISH;
          else                            lvl_q   <= lvl_q + LVL_W'(1);
        end
        ST_FINISH: begin
          min1_q  <= val_q[0];
          min2_q  <= min2_d;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign min1_o = min1_q;
  assign min2_o = min2_q;
endmodule

// File: rtl/tmin2_chk.sv
module tmin2_chk #(
  parameter int DATA_W = 8,
  parameter int LOG_N  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              done_o,
  input logic [DATA_W-1:0] min1_o,
  input logic [DATA_W-1:0] min2_o
);
  localparam int CNT_W = $clog2(LOG_N + 2);

  logic             busy_q, due_q;
  logic [CNT_W-1:0] cnt_q;

  // Independent latency tracker: accept when idle, expect done L+1 edges later.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      due_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      due_q <= busy_q && (cnt_q == CNT_W'(LOG_N));
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
        end
      end else if (cnt_q == CNT_W'(LOG_N)) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  a_r2_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r2_done_on_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    due_q |-> done_o);

  a_r7_no_stray_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> due_q);

  a_r4_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (min1_o <= min2_o));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(min1_o) && $stable(min2_o)));
endmodule

bind tmin2_top tmin2_chk #(
  .DATA_W (DATA_W),
  .LOG_N  (LOG_N)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .done_o  (done_o),
  .min1_o  (min1_o),
  .min2_o  (min2_o)
);

// File: tb/tmin2_top_test.sv
`timescale 1ns/1ps
module tmin2_top_test;
  localparam int M  = 8;
  localparam int L  = 3;
  localparam int N  = 1 << L;
  localparam int WD = 100000;

  logic             clk_i   = 1'b0;
  logic             rst_ni  = 1'b0;
  logic             start_i = 1'b0;
  logic [N*M-1:0]   data_i  = '0;
  logic             done_o;
  logic [M-1:0]     min1_o, min2_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  tmin2_top #(.DATA_W(M), .LOG_N(L)) uut (.*);

  always #4 clk_i = ~clk_i;

  task automatic chk(bit ok, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic void ref_min2(logic [N*M-1:0] d, output int e1, output int e2);
    int q[$];
    for (int i = 0; i < N; i++) q.push_back(int'(d[i*M +: M]));
    q.sort();
    e1 = q[0];
    e2 = q[1];
  endfunction

  function automatic logic [N*M-1:0] pk(int v[N]);
    logic [N*M-1:0] r;
    for (int i = 0; i < N; i++) r[i*M +: M] = M'(v[i]);
    return r;
  endfunction

  // Reference model: countdown per accepted set, results appear when it expires.
  int m_cnt, m1, m2, p1, p2;
  bit m_done;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_done = 0; m1 = 0; m2 = 0; p1 = 0; p2 = 0;
    end else begin
      m_done = 0;
      if (m_cnt != 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_done = 1; m1 = p1; m2 = p2;
        end
      end else if (start_i) begin
        ref_min2(data_i, p1, p2);
        m_cnt = L + 1;
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk(done_o == m_done, "R2/R7/R8 done strobe", int'(done_o), int'(m_done));
      chk(int'(min1_o) == m1, "R3/R6 min1 vs model", int'(min1_o), m1);
      chk(int'(min2_o) == m2, "R4/R6 min2 vs model", int'(min2_o), m2);
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WD) begin
      total++; bad++;
      $display("FAIL R2 watchdog: actual=%0d expected<%0d", cyc, WD);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_set(logic [N*M-1:0] d, int e1, int e2, string tag);
    @(negedge clk_i); data_i = d; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    repeat (L) @(negedge clk_i);
    chk(done_o == 1'b0, {tag, " R2 no early done"}, int'(done_o), 0);
    @(negedge clk_i);
    chk(done_o == 1'b1, {tag, " R2 done"}, int'(done_o), 1);
    chk(int'(min1_o) == e1, {tag, " R3 min1"}, int'(min1_o), e1);
    chk(int'(min2_o) == e2, {tag, " R4 min2"}, int'(min2_o), e2);
  endtask

  task automatic run_auto(logic [N*M-1:0] d, string tag);
    int e1, e2;
    ref_min2(d, e1, e2);
    run_set(d, e1, e2, tag);
  endtask

  initial begin
    int v[N];
    int e1, e2, f1, f2;
    logic [N*M-1:0] d1, d2;

    repeat (3) @(negedge clk_i);
    chk(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
    chk(min1_o == '0,   "R1 reset min1", int'(min1_o), 0);
    chk(min2_o == '0,   "R1 reset min2", int'(min2_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(done_o == 1'b0, "R1 idle after reset", int'(done_o), 0);

    // R9 worked example
    v = '{10, 1, 5, 8, 7, 9, 12, 11};
    run_set(pk(v), 1, 5, "R9 example");

    // R5 ties
    v = '{33, 33, 33, 33, 33, 33, 33, 33};
    run_set(pk(v), 33, 33, "R5 all equal");
    v = '{20, 40, 9, 4, 50, 60, 4, 70};
    run_set(pk(v), 4, 4, "R5 duplicate min");

    // R10 extremes
    v = '{255, 255, 255, 255, 255, 255, 255, 255};
    run_set(pk(v), 255, 255, "R10 all max");
    v = '{200, 90, 80, 70, 60, 50, 1, 0};
    run_set(pk(v), 0, 1, "R10 top pair");
    v = '{0, 255, 255, 255, 255, 255, 255, 254};
    run_set(pk(v), 0, 254, "R10 far apart");

    // R3 R4 random sets, half of them in a narrow range to force ties
    for (int r = 0; r < 40; r++) begin
      for (int i = 0; i < N; i++)
        d1[i*M +: M] = (r % 2 == 0) ? M'($urandom_range(0, 255)) : M'($urandom_range(0, 7));
      run_auto(d1, "R3 R4 random");
    end

    // R7 start during a run is ignored
    v = '{30, 31, 32, 33, 34, 35, 36, 37}; d1 = pk(v);
    v = '{1, 2, 3, 4, 5, 6, 7, 8};         d2 = pk(v);
    @(negedge clk_i); data_i = d1; start_i = 1'b1;
    @(negedge clk_i); data_i = d2; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    repeat (L - 1) @(negedge clk_i);
    chk(done_o == 1'b0, "R7 no early done", int'(done_o), 0);
    @(negedge clk_i);
    chk(done_o == 1'b1, "R7 done on time", int'(done_o), 1);
    chk(int'(min1_o) == 30, "R7 min1 of first set", int'(min1_o), 30);
    chk(int'(min2_o) == 31, "R7 min2 of first set", int'(min2_o), 31);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R7 single done", int'(done_o), 0);

    // R8 start in the done cycle
    v = '{90, 80, 70, 60, 50, 40, 30, 20}; d1 = pk(v);
    v = '{9, 3, 250, 3, 100, 2, 200, 77};  d2 = pk(v);
    ref_min2(d2, f1, f2);
    @(negedge clk_i); data_i = d1; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    repeat (L) @(negedge clk_i);
    @(negedge clk_i);
    chk(done_o == 1'b1, "R8 first done", int'(done_o), 1);
    chk(int'(min1_o) == 20, "R8 first min1", int'(min1_o), 20);
    chk(int'(min2_o) == 30, "R8 first min2", int'(min2_o), 30);
    data_i = d2; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    repeat (L) @(negedge clk_i);
    @(negedge clk_i);
    chk(done_o == 1'b1, "R8 second done", int'(done_o), 1);
    chk(int'(min1_o) == f1, "R8 second min1", int'(min1_o), f1);
    chk(int'(min2_o) == f2, "R8 second min2", int'(min2_o), f2);

    // R6 hold while data_i churns with start low
    e1 = int'(min1_o); e2 = int'(min2_o);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_i);
      for (int i = 0; i < N; i++) data_i[i*M +: M] = M'($urandom_range(0, 255));
    end
    @(negedge clk_i);
    chk(int'(min1_o) == e1, "R6 min1 held", int'(min1_o), e1);
    chk(int'(min2_o) == e2, "R6 min2 held", int'(min2_o), e2);
    chk(done_o == 1'b0, "R6 no done while idle", int'(done_o), 0);

    repeat (3) @(negedge clk_i);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule